// File: doc/BRIEF.md
# PCI Memory Target Data-Phase Controller

This block answers memory read and memory write transactions on a 32-bit multiplexed address/data bus as a simple target. It watches the cycle-frame, initiator-ready and command/byte-enable lines. It drives device-select, target-ready and stop, and it drives the data lines during reads. A small word-addressed register file sits behind it. The block claims one fixed 256-byte window. It follows the address phase, any number of data phases and the final data phase, and it ends a long burst with a disconnect.

Every active-low output is presented as a value plus an output enable, so the pad ring decides when the line floats. Initiator-ready and target-ready act as a valid/ready pair for each data phase. The target never stalls once it is in a data phase, so back-pressure comes only from the initiator. While initiator-ready is high, the address, the read data and the register contents hold still. A data phase completes only on an edge where both ready lines are low. The transaction ends on the completion that is sampled with cycle-frame high. No length is ever given to the block.

Top module: `pci_tgt_dphase`

## Requirements
- R1: The reset is active low and asynchronous. While it is asserted every output enable (`devsel_oe`, `trdy_oe`, `stop_oe`, `ad_oe`) is 0 at once, without waiting for a clock, and every register-file word is cleared to zero.
- R2: An address phase is a clock where `frame_n` is low while the block is idle. It is claimed when `ad_in[31:8]` equals `BASE_ADDR[31:8]` and `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write). On a claim, `devsel_n` is driven low in the next cycle.
- R3: On a claimed write, `trdy_n` is driven low in the same cycle as `devsel_n`. Each completed phase writes the bytes of `ad_in` whose `cbe_n` bit is 0 into the current word. Byte lane b is `ad_in[8b+7:8b]`.
- R4: On a claimed read, the cycle after the address phase is a turnaround cycle: `devsel_n` is low, `trdy_n` is driven high and `ad_oe` is 0. From the following cycle onward, `trdy_n` is low, `ad_oe` is 1 and `ad_out` carries the current word.
- R5: A data phase completes only on an edge where `irdy_n` and `trdy_n` are both low. On a wait cycle (`irdy_n` high) nothing is written, the current word index holds and `ad_out` is unchanged.
- R6: The first word index is `ad_in[7:2]` of the address phase. It advances by one on each completed phase and wraps modulo 64 inside the window.
- R7: A completion sampled with `frame_n` high is the last one. In the next cycle, `devsel_n`, `trdy_n` and `stop_n` are driven high with their enables at 1. In the cycle after that, all enables are 0.
- R8: During the 8th data phase of a burst, `stop_n` is low together with `trdy_n`. If that phase completes with `frame_n` still low, the block keeps `devsel_n` and `stop_n` low and drives `trdy_n` high until `frame_n` is sampled high. It then releases as in R7, and no further data moves.
- R9: An address phase that is not claimed (wrong address or any other command) leaves every output enable at 0 and the register file unchanged. The block waits until `frame_n` and `irdy_n` are both high before it looks for another address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous bus reset, active low |
| frame_n | input | 1 | Cycle frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Address/data lines as sampled |
| ad_out | output | 32 | Read data presented to the address/data lines |
| ad_oe | output | 1 | Enable for `ad_out` |
| devsel_n | output | 1 | Device-select value, active low |
| devsel_oe | output | 1 | Enable for `devsel_n` |
| trdy_n | output | 1 | Target-ready value, active low |
| trdy_oe | output | 1 | Enable for `trdy_n` |
| stop_n | output | 1 | Stop value, active low |
| stop_oe | output | 1 | Enable for `stop_n` |

## Verification
The assertions assume that the initiator follows the bus protocol. Cycle-frame goes low only at an address phase. Cycle-frame is raised only in the same cycle that initiator-ready is asserted for the last phase. Once initiator-ready is low, it stays low until the phase completes. The stimulus comes from a single initiator task that obeys these rules. It inserts wait cycles from a per-transaction mask and drives all-byte garbage during those waits, so a write that leaked through a wait would leave marks that a later read-back exposes. Unclaimed cycles are driven by a separate task that raises cycle-frame after one data cycle, just as a master abort would.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_XFER,
    ST_DRAIN,
    ST_RELS,
    ST_SKIP
  } tgt_st_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_BITS  = 8,
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  output logic              hit,
  output logic              is_rd
);
  logic in_win;
  logic mem_cmd;

  assign in_win  = (addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
  assign mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  assign hit     = in_win && mem_cmd;
  assign is_rd   = (cmd == CMD_MEM_RD);
endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile #(
  parameter int IDX_W = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANES-1:0]   be_n,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  localparam int WORDS = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) lane_q[w] <= '0;
      end else if (we && !be_n[g]) begin
        lane_q[idx] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = lane_q[idx];

    // R5: a lane without a write keeps the word it presents
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(we && !be_n[g])) |=> (lane_q[$past(idx)] == $past(rdata[8*g +: 8]))); // R5
  end
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int BURST_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             hit,
  input  logic             is_rd,
  input  logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             devsel_oe,
  output logic             trdy_n,
  output logic             trdy_oe,
  output logic             stop_n,
  output logic             stop_oe
);
  localparam int CNT_W = $clog2(BURST_MAX + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(BURST_MAX - 1);

  tgt_st_e          st;
  logic             rd_q;
  logic [CNT_W-1:0] cnt;
  logic             done;
  logic             at_lim;
  logic             drv;
  logic             act;

  assign done   = (st == ST_XFER) && !irdy_n;
  assign at_lim = (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      rd_q <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (!frame_n) begin
          if (hit) begin
            st   <= is_rd ? ST_TURN : ST_XFER;
            rd_q <= is_rd;
            idx  <= start_idx;
            cnt  <= '0;
          end else begin
            st <= ST_SKIP;
          end
        end
        ST_TURN: st <= ST_XFER;
        ST_XFER: if (done) begin
          idx <= idx + 1'b1;
          cnt <= cnt + 1'b1;
          if (frame_n)     st <= ST_RELS;
          else if (at_lim) st <= ST_DRAIN;
        end
        ST_DRAIN: if (frame_n) st <= ST_RELS;
        ST_RELS:  st <= ST_IDLE;
        ST_SKIP:  if (frame_n && irdy_n) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    drv       = st inside {ST_TURN, ST_XFER, ST_DRAIN, ST_RELS};
    act       = st inside {ST_TURN, ST_XFER, ST_DRAIN};
    devsel_oe = drv;
    trdy_oe   = drv;
    stop_oe   = drv;
    devsel_n  = !act;
    trdy_n    = !(st == ST_XFER);
    stop_n    = !(((st == ST_XFER) && at_lim) || (st == ST_DRAIN));
    ad_oe     = (st == ST_XFER) && rd_q;
    wr_en     = done && !rd_q;
  end

  AST_DEVSEL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !frame_n && hit) |=> (devsel_oe && !devsel_n)); // R2
  AST_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !frame_n && !hit) |=> !devsel_oe); // R9
  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> $stable(idx)); // R5
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && frame_n) |=> (trdy_oe && trdy_n && devsel_n && stop_n)); // R7
  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_oe) |-> ($past(trdy_n) && $past(devsel_n) && $past(stop_n))); // R7
  AST_STOP_WITH_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n) |-> (!trdy_n && stop_oe)); // R8
endmodule

// File: rtl/pci_tgt_dphase.sv
module pci_tgt_dphase #(
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
  parameter int          WIN_BITS  = 8,
  parameter int          BURST_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        devsel_oe,
  output logic        trdy_n,
  output logic        trdy_oe,
  output logic        stop_n,
  output logic        stop_oe
);
  localparam int IDX_W = WIN_BITS - 2;

  logic             hit;
  logic             is_rd;
  logic             wr_en;
  logic [IDX_W-1:0] idx;

  pci_tgt_decode #(
    .ADDR_W   (32),
    .WIN_BITS (WIN_BITS),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr (ad_in),
    .cmd  (cbe_n),
    .hit  (hit),
    .is_rd(is_rd)
  );

  pci_tgt_fsm #(
    .IDX_W    (IDX_W),
    .BURST_MAX(BURST_MAX)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .hit      (hit),
    .is_rd    (is_rd),
    .start_idx(ad_in[WIN_BITS-1:2]),
    .idx      (idx),
    .wr_en    (wr_en),
    .ad_oe    (ad_oe),
    .devsel_n (devsel_n),
    .devsel_oe(devsel_oe),
    .trdy_n   (trdy_n),
    .trdy_oe  (trdy_oe),
    .stop_n   (stop_n),
    .stop_oe  (stop_oe)
  );

  pci_tgt_regfile #(
    .IDX_W(IDX_W),
    .LANES(4)
  ) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .idx  (idx),
    .be_n (cbe_n),
    .wdata(ad_in),
    .rdata(ad_out)
  );

  AST_WR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!irdy_n && trdy_oe && !trdy_n)); // R5
  AST_AD_WITH_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (trdy_oe && !trdy_n && !devsel_n)); // R4
endmodule

// File: tb/pci_tgt_dphase_test.sv
module pci_tgt_dphase_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0001_0000;
  localparam int          BURST      = 8;
  localparam logic [3:0]  MRD        = 4'b0110;
  localparam logic [3:0]  MWR        = 4'b0111;

  typedef struct packed {
    logic [3:0] cmd;
    logic [5:0] off;
    logic [3:0] nph;
    logic [7:0] wm;
    logic [3:0] be;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{MWR, 6'd0,  4'd4,  8'b0000_0000, 4'b0000, 8'h11},
    '{MRD, 6'd0,  4'd4,  8'b0101_0010, 4'b0000, 8'h00},
    '{MWR, 6'd2,  4'd3,  8'b0110_0110, 4'b1100, 8'h22},
    '{MRD, 6'd0,  4'd6,  8'b0010_0001, 4'b0000, 8'h00},
    '{MWR, 6'd62, 4'd4,  8'b0000_0000, 4'b0011, 8'h33},
    '{MRD, 6'd62, 4'd5,  8'b1000_0100, 4'b0000, 8'h00},
    '{MWR, 6'd10, 4'd10, 8'b0001_0000, 4'b0000, 8'h44},
    '{MRD, 6'd8,  4'd12, 8'b0000_0000, 4'b0000, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [31:0] shadow [64];

  pci_tgt_dphase uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n),
    .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // {devsel_oe, trdy_oe, stop_oe, ad_oe}
  function automatic logic [31:0] oes();
    return {28'd0, devsel_oe, trdy_oe, stop_oe, ad_oe};
  endfunction

  // {devsel_n, trdy_n, stop_n}
  function automatic logic [31:0] vals();
    return {29'd0, devsel_n, trdy_n, stop_n};
  endfunction

  task automatic run_xfer(input logic [3:0] cmd, input logic [5:0] off, input int nph,
                          input logic [7:0] wm, input logic [3:0] be, input logic [7:0] seed);
    logic       rd = (cmd == MRD);
    logic [5:0] idx = off;
    int         done = 0;
    int         step = 0;
    logic       fin = 1'b0;
    logic       drain = 1'b0;
    logic [31:0] data;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = BASE | {24'd0, off, 2'b00}; cbe_n = cmd;
    @(negedge clk);
    chk("R2 devsel after address", {31'd0, devsel_oe && !devsel_n}, 32'd1);
    if (rd) begin
      chk("R4 turnaround trdy high ad off", {28'd0, trdy_oe, trdy_n, ad_oe, devsel_n}, 32'b1100);
      irdy_n = 1'b1; ad_in = '0;
      @(negedge clk);
    end else begin
      chk("R3 trdy with devsel", {31'd0, trdy_oe && !trdy_n}, 32'd1);
    end
    while (!fin && !drain) begin
      chk(rd ? "R4 data phase outputs" : "R3 data phase outputs",
          {28'd0, devsel_oe, devsel_n, trdy_oe, trdy_n}, 32'b1010);
      chk("R8 stop on phase 8", {31'd0, stop_n}, {31'd0, !(done == BURST - 1)});
      if (rd) begin
        chk("R4 ad enabled", {31'd0, ad_oe}, 32'd1);
        chk("R5 R6 read word", ad_out, shadow[idx]);
      end
      if (wm[step % 8]) begin
        irdy_n = 1'b1; frame_n = 1'b0;
        ad_in = 32'hBAD0_0000 | 32'(step); cbe_n = 4'b0000;
      end else begin
        data = {seed, 8'(done), 2'b00, off, 8'h5A};
        irdy_n = 1'b0;
        frame_n = (done == nph - 1);
        ad_in = data;
        cbe_n = rd ? 4'b0000 : be;
        if (!rd)
          for (int b = 0; b < 4; b++)
            if (!be[b]) shadow[idx][8*b +: 8] = data[8*b +: 8];
        if (done == nph - 1) fin = 1'b1;
        else if (done == BURST - 1) drain = 1'b1;
        idx = idx + 1'b1;
        done++;
      end
      step++;
      @(negedge clk);
    end
    if (drain) begin
      chk("R8 disconnect hold", {28'd0, vals(), trdy_oe}, {28'd0, 3'b010, 1'b1});
      frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000; ad_in = 32'hDEAD_BEEF;
      @(negedge clk);
    end
    chk("R7 driven high before release", {28'd0, devsel_oe, trdy_oe, stop_oe, 1'b0} | vals(),
        32'b1110 | 32'b0111);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    chk("R7 released", oes(), 32'd0);
  endtask

  task automatic run_unclaimed(input logic [31:0] addr, input logic [3:0] cmd);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    chk("R9 no claim", oes(), 32'd0);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hFFFF_FFFF; cbe_n = 4'b0000;
    @(negedge clk);
    chk("R9 no drive in data", oes(), 32'd0);
    irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    chk("R9 idle after", oes(), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset enables", oes(), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", oes(), 32'd0);

    for (int i = 0; i < 8; i++)
      run_xfer(TBL[i].cmd, TBL[i].off, int'(TBL[i].nph), TBL[i].wm, TBL[i].be, TBL[i].seed);

    // R9: outside the window, then a non-memory command inside it
    run_unclaimed(32'h0002_0000, MWR);
    run_unclaimed(BASE, 4'b0011);
    run_xfer(MRD, 6'd0, 1, 8'h00, 4'h0, 8'h00);

    // R1: asynchronous reset in the middle of a write burst
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = BASE | 32'h10; cbe_n = MWR;
    @(negedge clk);
    chk("R1 claimed before reset", {31'd0, devsel_oe}, 32'd1);
    #2 rst_n = 1'b0;
    #1 chk("R1 async release", oes(), 32'd0);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_xfer(MRD, 6'd0, 4, 8'b0000_0010, 4'h0, 8'h00);
    run_xfer(MRD, 6'd10, 2, 8'h00, 4'h0, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule